// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

A synchronous controller that sits between a host request port and an asynchronous, 4-bit-wide DRAM. The DRAM takes its row and column over one shared address bus. Each accepted request carries a 22-bit word address, a write flag and 4 bits of write data. The sequencer splits the address into a row and a column. It opens the row by dropping the row strobe and then strobes the column with the column strobe. While the row stays open, later requests to the same row are served as page hits: only the column strobe cycles, with a new column.

The sequencer closes the open row in three cases: a request arrives for another row, a refresh is pending, or the row strobe has been low so long that one more hit would break the maximum row-active time. After closing, the row strobe stays high for the precharge time. Writes are always early writes: the write strobe and the driven data are set up a cycle before the column strobe falls. Reads sample the data bus on the last cycle of the column strobe's low time. All DRAM timings are parameters counted in clock cycles. A separate refresh block asks for the DRAM with a request line. The sequencer grants it only after the current access has finished and the row is closed.

Top module: `dram_page_seq`

## Requirements
- R1: With ROW_W=12 the row is addr[21:10] and the column is addr[9:0]. With ROW_W=11 the row is addr[21:11] and the column is addr[10:0]. The address bus is max(row, column) bits wide, and unused upper bits are driven 0.
- R2: The row value is on the address bus at least one cycle before the row strobe falls. The column value is on the bus at least one cycle before the column strobe falls.
- R3: On a write, the write strobe is low, the data output enable is high, the output enable is high and the data output equals the request's data. All of these hold from the cycle before the column strobe falls. On a read, the write strobe and the output enable for the data pins are inactive and the output enable is low.
- R4: The column strobe stays low for exactly T_CAS cycles. A read returns the data bus value sampled at the last of those cycles, with a one-cycle rd_valid pulse in the next cycle.
- R5: After the row strobe falls, the column strobe falls no earlier than T_RCD+1 cycles later.
- R6: A request to the open row is served without a new fall of the row strobe.
- R7: A request to a different row raises the row strobe, keeps it high for at least T_RP cycles, and then opens the new row.
- R8: The row strobe is never low for more than T_RAS_MAX cycles. The row is closed when one more hit (T_CAS+2 cycles) would not fit, whether hits are pending or the bus is idle.
- R9: ref_gnt is high only while both strobes are high, no read is outstanding and req_ready is low. It stays high until ref_req drops.
- R10: During and right after reset, all strobes are high, the data output enable is low, and rd_valid and ref_gnt are low.
- R11: A request is taken on a cycle with req_valid and req_ready both high. Every accepted request is served in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DQ_W | Read data |
| ref_req | input | 1 | Refresh block wants the DRAM |
| ref_gnt | output | 1 | DRAM handed to the refresh block |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | BUS_W | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The bench's DRAM model returns the inverse of the stored data until the column strobe has been low for T_CAS cycles. A sequencer that samples one cycle early therefore returns wrong data. A run of eight same-row accesses must open the row exactly twice. A design without the row-active limit opens it once and keeps the row strobe low too long. A refresh raised just after a read is accepted must wait for that read's data. An early grant would show up while the row strobe is low or a read is still outstanding. Separately, an instance with the 11/11 address split is checked on the bus at both strobe falls, which catches a split that ignores the parameter.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_ACT, S_COL, S_CAS, S_OPEN, S_PRE, S_REF
  } dps_state_e;

  // cycles one page hit occupies: column setup, strobe low time, return to open
  function automatic int unsigned hit_cost(int unsigned t_cas);
    return t_cas + 2;
  endfunction

  // true when cycles already spent plus the next cost stay inside the limit
  function automatic logic page_fits(int unsigned used, int unsigned cost,
                                     int unsigned limit);
    return (used + cost) <= limit;
  endfunction

endpackage

// File: rtl/dps_addr_split.sv
module dps_addr_split #(
  parameter int ADDR_W = 22,
  parameter int ROW_W  = 12,
  parameter int BUS_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BUS_W-1:0]  row_o,
  output logic [BUS_W-1:0]  col_o
);
  localparam int COL_W = ADDR_W - ROW_W;

  generate
    if (ROW_W == BUS_W) begin : g_row_full
      assign row_o = addr_i[ADDR_W-1 -: ROW_W];
    end else begin : g_row_pad
      assign row_o = {{(BUS_W-ROW_W){1'b0}}, addr_i[ADDR_W-1 -: ROW_W]};
    end
    if (COL_W == BUS_W) begin : g_col_full
      assign col_o = addr_i[COL_W-1:0];
    end else begin : g_col_pad
      assign col_o = {{(BUS_W-COL_W){1'b0}}, addr_i[COL_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/dps_ras_timer.sv
module dps_ras_timer import dps_pkg::*; #(
  parameter int T_RAS_MAX = 24,
  parameter int HIT_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low_i,
  output logic hit_fits_o
);
  localparam int CW = $clog2(T_RAS_MAX + 2);

  logic [CW-1:0] low_cnt_q;
  logic [31:0]   used_now;

  assign used_now   = 32'(low_cnt_q) + 32'd1;
  assign hit_fits_o = page_fits(used_now, HIT_CYC, T_RAS_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt_q <= '0;
    else if (!ras_low_i)             low_cnt_q <= '0;
    else if (low_cnt_q != '1)        low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R8: a cycle with the row strobe low never goes beyond the limit
  a_r8_ras_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low_i |-> (used_now <= 32'(T_RAS_MAX)));
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq import dps_pkg::*; #(
  parameter int ADDR_W    = 22,
  parameter int ROW_W     = 12,
  parameter int DQ_W      = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 24,
  localparam int COL_W    = ADDR_W - ROW_W,
  localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [BUS_W-1:0]  dram_addr,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);
  localparam int T_LONG  = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                           : ((T_CAS > T_RP) ? T_CAS : T_RP);
  localparam int CNT_W   = $clog2(T_LONG + 1);
  localparam int HIT_CYC = hit_cost(T_CAS);

  dps_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic [DQ_W-1:0]   cur_wd;

  // named internal events
  logic [BUS_W-1:0] req_row, req_col, cur_row, cur_col;
  logic page_hit, hit_fits, close_page, take_req, ras_low, col_phase;

  dps_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BUS_W(BUS_W)) u_req_split (
    .addr_i(req_addr), .row_o(req_row), .col_o(req_col));
  dps_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BUS_W(BUS_W)) u_cur_split (
    .addr_i(cur_addr), .row_o(cur_row), .col_o(cur_col));

  dps_ras_timer #(.T_RAS_MAX(T_RAS_MAX), .HIT_CYC(HIT_CYC)) u_ras_timer (
    .clk(clk), .rst_n(rst_n), .ras_low_i(ras_low), .hit_fits_o(hit_fits));

  assign page_hit   = (req_row == cur_row);
  assign close_page = ref_req || !hit_fits || (req_valid && !page_hit);
  assign req_ready  = ((state == S_IDLE) && !ref_req) ||
                      ((state == S_OPEN) && !close_page);
  assign take_req   = req_valid && req_ready;

  assign ras_low    = (state == S_ACT) || (state == S_COL) ||
                      (state == S_CAS) || (state == S_OPEN);
  assign col_phase  = (state == S_COL) || (state == S_CAS);

  assign dram_ras_n  = !ras_low;
  assign dram_cas_n  = (state != S_CAS);
  assign dram_we_n   = !(col_phase && cur_we);
  assign dram_oe_n   = !(col_phase && !cur_we);
  assign dram_dq_oe  = col_phase && cur_we;
  assign dram_dq_out = cur_wd;
  assign dram_addr   = ((state == S_ROW) || (state == S_ACT)) ? cur_row : cur_col;
  assign ref_gnt     = (state == S_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cur_addr <= '0;
      cur_we   <= 1'b0;
      cur_wd   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (take_req) begin
        cur_addr <= req_addr;
        cur_we   <= req_we;
        cur_wd   <= req_wdata;
      end
      case (state)
        S_IDLE: begin
          if (ref_req)        state <= S_REF;
          else if (req_valid) state <= S_ROW;
        end
        S_ROW: begin
          state <= S_ACT;
          cnt   <= CNT_W'(T_RCD - 1);
        end
        S_ACT: begin
          if (cnt == '0) state <= S_COL;
          else           cnt   <= cnt - 1'b1;
        end
        S_COL: begin
          state <= S_CAS;
          cnt   <= CNT_W'(T_CAS - 1);
        end
        S_CAS: begin
          if (cnt == '0) begin
            state <= S_OPEN;
            if (!cur_we) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_OPEN: begin
          if (close_page) begin
            state <= S_PRE;
            cnt   <= CNT_W'(T_RP - 1);
          end else if (req_valid) begin
            state <= S_COL;
          end
        end
        S_PRE: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        S_REF: begin
          if (!ref_req) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: bus holds its value across the strobe falls
  a_r2_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  // R3: write strobe and data drive are set up before the column strobe falls
  a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> ($stable(dram_we_n) && $stable(dram_dq_oe)));
  // R4: the column strobe is only low inside an open row
  a_r4_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  // R6: an accepted hit keeps the row strobe low
  a_r6_hit_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_OPEN) && take_req) |=> !dram_ras_n);
  // R9: the grant only appears with both strobes idle and no intake
  a_r9_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));
endmodule

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RAS_MAX = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, dq_in = '0;
  logic        req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  rd_data, dq_out;
  logic [11:0] dbus;

  dram_page_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX))
  u_dram_page_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dbus), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  // second instance with the 11/11 split
  logic        n_valid = 1'b0, n_ready, n_rdv, n_gnt, n_ras, n_cas, n_we, n_oe, n_dqoe;
  logic [21:0] n_addr = '0;
  logic [3:0]  n_rdd, n_dqo;
  logic [10:0] n_bus;
  logic        n_zero = 1'b0;
  logic [3:0]  n_zd = '0;

  dram_page_seq #(.ROW_W(11), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
                  .T_RAS_MAX(T_RAS_MAX))
  u_dram_page_seq_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_ready(n_ready),
    .req_addr(n_addr), .req_we(n_zero), .req_wdata(n_zd),
    .rd_valid(n_rdv), .rd_data(n_rdd), .ref_req(n_zero), .ref_gnt(n_gnt),
    .dram_ras_n(n_ras), .dram_cas_n(n_cas), .dram_we_n(n_we), .dram_oe_n(n_oe),
    .dram_addr(n_bus), .dram_dq_out(n_dqo), .dram_dq_oe(n_dqoe), .dram_dq_in(n_zd));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {logic we; logic [21:0] addr; logic [3:0] d; logic op;} acc_t;
  acc_t       acq[$];
  logic [3:0] rdq[$];
  logic [3:0] emem[int];
  logic [3:0] dmem[int];

  // DRAM model and pin monitor, all at the falling clock edge
  logic pr = 1'b1, pc = 1'b1, opened = 1'b0;
  int   rl = 0, rh = 100, since_ras = 0, cl = 0;
  logic [11:0] m_row = '0, m_col = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pr && !ras_n) begin
        check(rh >= T_RP, "R7 precharge", rh, T_RP);
        m_row = dbus; opened = 1'b1; since_ras = 1;
      end else if (!ras_n) since_ras++;
      if (!pr && ras_n) check(rl <= T_RAS_MAX, "R8 row active", rl, T_RAS_MAX);
      if (pc && !cas_n) begin
        acc_t a;
        m_col = dbus; cl = 1;
        if (acq.size() == 0) check(0, "R11 unexpected access", 0, 1);
        else begin
          a = acq.pop_front();
          check(m_row == a.addr[21:10], "R1 row", m_row, a.addr[21:10]);
          check(dbus == {2'b00, a.addr[9:0]}, "R1 col", dbus, a.addr[9:0]);
          check(opened == a.op, "R6 row open", opened, a.op);
          if (a.op) check(since_ras >= T_RCD + 2, "R5 row to col", since_ras, T_RCD + 2);
          if (a.we) check(!we_n && dq_oe && oe_n && dq_out == a.d, "R3 write",
                          {we_n, dq_oe, oe_n, dq_out}, {3'b011, a.d});
          else      check(we_n && !dq_oe && !oe_n, "R3 read", {we_n, dq_oe, oe_n}, 3'b100);
        end
        if (!we_n) dmem[{m_row[11:0], m_col[9:0]}] = dq_out;
        opened = 1'b0;
      end else if (!cas_n) cl++;
      if (!pc && cas_n) check(cl == T_CAS, "R4 strobe width", cl, T_CAS);
      if (rd_valid) begin
        if (rdq.size() == 0) check(0, "R4 stray read", 0, 1);
        else begin
          logic [3:0] e;
          e = rdq.pop_front();
          check(rd_data == e, "R4 read data", rd_data, e);
        end
      end
      if (ref_gnt) check(ras_n && cas_n && rdq.size() == 0, "R9 grant",
                         {ras_n, cas_n, rdq.size() == 0}, 3'b111);
      rl = ras_n ? 0 : rl + 1;
      rh = ras_n ? rh + 1 : 0;
      pr = ras_n; pc = cas_n;
      if (!cas_n) begin
        logic [3:0] v;
        v = dmem.exists({m_row[11:0], m_col[9:0]}) ? dmem[{m_row[11:0], m_col[9:0]}] : 4'h0;
        dq_in = (cl >= T_CAS) ? v : ~v;
      end else dq_in = 4'h0;
    end
  end

  task automatic issue(input logic we, input logic [21:0] a, input logic [3:0] d,
                       input logic op);
    acc_t e;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    e = '{we: we, addr: a, d: d, op: op};
    acq.push_back(e);
    if (we) emem[a] = d;
    else rdq.push_back(emem.exists(a) ? emem[a] : 4'h0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic narrow_access(input logic [21:0] a);
    @(negedge clk);
    n_valid = 1'b1; n_addr = a;
    #1;
    while (!n_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    n_valid = 1'b0;
    while (n_ras) @(negedge clk);
    check(n_bus == a[21:11], "R1 narrow row", n_bus, a[21:11]);
    while (n_cas) @(negedge clk);
    check(n_bus == a[10:0], "R1 narrow col", n_bus, a[10:0]);
  endtask

  // stimulus table: {we, row[11:0], col[9:0], data}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 12'h005, 10'h003, 4'hA},
    {1'b1, 12'h005, 10'h007, 4'h3},
    {1'b0, 12'h005, 10'h003, 4'h0},
    {1'b0, 12'h005, 10'h007, 4'h0},
    {1'b1, 12'h009, 10'h003, 4'h6},
    {1'b0, 12'h005, 10'h003, 4'h0},
    {1'b0, 12'h009, 10'h003, 4'h0},
    {1'b1, 12'h009, 10'h3FF, 4'hF},
    {1'b0, 12'hFFF, 10'h000, 4'h0},
    {1'b0, 12'h009, 10'h3FF, 4'h0}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [11:0] prev_row;
    repeat (3) @(negedge clk);
    // R10: reset values
    check(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && !ref_gnt,
          "R10 reset", {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, ref_gnt}, 7'b1111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && !dq_oe && !rd_valid && !ref_gnt && req_ready,
          "R10 after reset", {ras_n, cas_n, dq_oe, rd_valid, ref_gnt, req_ready}, 6'b110001);

    // table walk; a row open is expected on the first access or a row change
    prev_row = '1;
    for (int i = 0; i < NV; i++) begin
      logic [11:0] r;
      r = VEC[i][25:14];
      issue(VEC[i][26], {r, VEC[i][13:4]}, VEC[i][3:0], (i == 0) || (r != prev_row));
      prev_row = r;
    end

    // R8: eight back-to-back hits on a fresh row need two row opens
    for (int c = 0; c < 8; c++)
      issue(1'b1, {12'h03C, 10'(c)}, 4'(c + 1), (c == 0) || (c == 5));

    // R8: an idle open row closes by itself
    repeat (T_RAS_MAX + 6) @(negedge clk);
    check(ras_n == 1'b1, "R8 idle close", ras_n, 1);
    issue(1'b0, {12'h03C, 10'd2}, 4'h0, 1'b1);

    // R9: refresh raised just after a read is taken waits for it
    issue(1'b0, {12'h005, 10'h007}, 4'h0, 1'b1);
    ref_req = 1'b1;
    while (!ref_gnt) @(negedge clk);
    req_valid = 1'b1; req_addr = {12'h005, 10'h003}; req_we = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!req_ready && ref_gnt, "R9 hold", {req_ready, ref_gnt}, 2'b01);
    end
    req_valid = 1'b0; ref_req = 1'b0;
    @(negedge clk);
    issue(1'b0, {12'h005, 10'h003}, 4'h0, 1'b1);

    // R1: alternative split on the second instance
    narrow_access(22'h2ABCDE);
    repeat (T_RAS_MAX + 10) @(negedge clk);
    narrow_access(22'h15432F);

    repeat (20) @(negedge clk);
    check(acq.size() == 0 && rdq.size() == 0, "R11 all served", acq.size() + rdq.size(), 0);
    summary();
  end
endmodule